// File: doc/BRIEF.md
# Paged Indirect Effective Address Resolver

This block turns the address field of a memory-reference instruction into the final 15-bit operand address for a 16-bit word machine. The caller pulses `start_i` with the instruction word and the current program counter. The block first forms a base address. The low ten bits come from the instruction. The upper five bits are either zero or the page bits of the program counter, so memory is seen as 32 pages of 1024 words.

If the instruction asks for a direct operand, the base address is the result. If it asks for an indirect operand, the block follows a pointer chain. Each word it reads is either a further pointer or the final address, as bit 15 of that word decides. The chain may have any length.

Memory words are read through a request/valid port that allows one read at a time. Words 0 and 1 are not read from memory: their values come straight from the two accumulator inputs. A level counter shows how far the chain has gone. An abort input lets the surrounding control stop a chain that never ends, such as a pointer that points to itself.

Top module: `hpea_resolver`

## Requirements
- R1: The low 10 bits of the base address equal instruction bits 9..0. When instruction bit 10 is 0, base address bits 14..10 are zero.
- R2: When instruction bit 10 is 1, base address bits 14..10 equal program counter bits 14..10.
- R3: When instruction bit 15 is 0, `ea_o` equals the base address and `done_o` is high in the cycle right after the start cycle. No read is issued and `level_o` is 0.
- R4: When instruction bit 15 is 1 and the base address is 2 or more, the first read request carries the base address. Every request stays high, with a stable address, until the cycle in which `rd_valid_i` is high.
- R5: Bit 15 of each word read is a pointer flag. If it is 1, bits 14..0 give the next read address. If it is 0, bits 14..0 become `ea_o`, and `done_o` is high in the following cycle.
- R6: A chain step at address 0 takes `acc_a_i` and a step at address 1 takes `acc_b_i`. Such a step raises no `rd_req_o` and takes exactly one cycle. A direct word found at address 0 gives `done_o` two cycles after the start cycle.
- R7: `level_o` is cleared at each accepted start. It counts the chain words consumed and stops at its maximum value of 2^LVL_W-1 (255 by default).
- R8: `done_o` is a one-cycle pulse and is never high while `busy_o` is high. A `start_i` that arrives while busy has no effect on the result.
- R9: `abort_i` while busy returns the block to idle in the next cycle. `busy_o` and `rd_req_o` go low and no `done_o` pulse is given.
- R10: After reset, `busy_o`, `done_o`, `rd_req_o`, `ea_o` and `level_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one resolution (accepted only when idle) |
| instr_i | input | 16 | Instruction word: bit 15 indirect flag, bit 10 page select, bits 9..0 offset |
| pc_i | input | 15 | Current program counter |
| acc_a_i | input | 16 | Accumulator A, the value seen at address 0 |
| acc_b_i | input | 16 | Accumulator B, the value seen at address 1 |
| abort_i | input | 1 | Stop a chain in progress |
| rd_req_o | output | 1 | Read request, held until valid |
| rd_addr_o | output | 15 | Read address |
| rd_valid_i | input | 1 | One-cycle read data valid |
| rd_data_i | input | 16 | Read data |
| busy_o | output | 1 | Chain walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| ea_o | output | 15 | Effective address, held until the next result |
| level_o | output | LVL_W | Number of chain words consumed (saturating) |

## Verification
The sweep crosses the page select, the indirect flag, five offsets and four program counter values, so that the page-zero and current-page bases can be told apart for each page. The offsets include the edges and the alias words. Indirect vectors use chains of zero to three pointers, built from a pseudo-random sequence, and a read latency of zero to two cycles. These vectors separate an early stop, a missed level and an unstable request. Directed cases cover:
- a chain that passes through accumulator B into memory;
- the exact cycle timing of direct and aliased results;
- a stray start during a long read;
- a self-pointing accumulator, which drives the level counter into saturation before an abort.

// File: rtl/hpea_pkg.sv
package hpea_pkg;
  localparam int unsigned WORD_W       = 16;
  localparam int unsigned ADDR_W       = 15;
  localparam int unsigned OFFS_W       = 10;
  localparam int unsigned PAGE_W       = ADDR_W - OFFS_W;
  localparam int unsigned IND_BIT      = WORD_W - 1;
  localparam int unsigned PAGE_SEL_BIT = OFFS_W;
  localparam int unsigned ALIAS_N      = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [OFFS_W-1:0] offs_t;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } walk_st_e;
endpackage

// File: rtl/hpea_page_base.sv
module hpea_page_base
  import hpea_pkg::*;
(
  input  logic  page_sel_i,
  input  page_t pc_page_i,
  input  offs_t offs_i,
  output addr_t base_o
);
  page_t page_bits;

  always_comb begin
    page_bits = page_sel_i ? pc_page_i : '0;
    base_o    = {page_bits, offs_i};
  end
endmodule

// File: rtl/hpea_alias_port.sv
module hpea_alias_port
  import hpea_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_want_i,
  input  addr_t                    addr_i,
  input  word_t [ALIAS_N-1:0]      alias_words_i,
  input  logic                     rd_valid_i,
  input  word_t                    rd_data_i,
  output logic                     rd_req_o,
  output addr_t                    rd_addr_o,
  output logic                     step_o,
  output word_t                    step_word_o
);
  logic [ALIAS_N-1:0] hit;
  word_t              masked [ALIAS_N];
  word_t              alias_word;
  logic               is_alias;

  for (genvar i = 0; i < ALIAS_N; i++) begin : g_alias
    assign hit[i]    = (addr_i == addr_t'(i));
    assign masked[i] = hit[i] ? alias_words_i[i] : '0;
  end

  always_comb begin
    alias_word = '0;
    for (int k = 0; k < ALIAS_N; k++) alias_word |= masked[k];
  end

  assign is_alias    = |hit;
  assign rd_req_o    = rd_want_i && !is_alias;
  assign rd_addr_o   = addr_i;
  // alias words are served in the same cycle, memory words on valid
  assign step_o      = rd_want_i && (is_alias || rd_valid_i);
  assign step_word_o = is_alias ? alias_word : rd_data_i;

  a_r6_no_alias_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o >= addr_t'(ALIAS_N)));

  a_r6_alias_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_want_i && (addr_i < addr_t'(ALIAS_N))) |-> (step_o && !rd_req_o));

  a_r8_alias_hit_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/hpea_walk_ctrl.sv
module hpea_walk_ctrl
  import hpea_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             indirect_i,
  input  addr_t            base_i,
  input  logic             step_i,
  input  word_t            step_word_i,
  output logic             rd_want_o,
  output addr_t            cur_addr_o,
  output logic             busy_o,
  output logic             done_o,
  output addr_t            ea_o,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  walk_st_e         state_q;
  addr_t            cur_q;
  addr_t            ea_q;
  logic             done_q;
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      ea_q    <= '0;
      done_q  <= 1'b0;
      level_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            level_q <= '0;
            if (indirect_i) begin
              cur_q   <= base_i;
              state_q <= ST_WALK;
            end else begin
              ea_q   <= base_i;
              done_q <= 1'b1;
            end
          end
        end
        ST_WALK: begin
          if (abort_i) begin
            state_q <= ST_IDLE;
          end else if (step_i) begin
            if (level_q != LVL_MAX) level_q <= level_q + 1'b1;
            if (step_word_i[IND_BIT]) begin
              cur_q <= step_word_i[ADDR_W-1:0];
            end else begin
              ea_q    <= step_word_i[ADDR_W-1:0];
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == ST_WALK);
  assign rd_want_o  = busy_o && !abort_i;
  assign cur_addr_o = cur_q;
  assign done_o     = done_q;
  assign ea_o       = ea_q;
  assign level_o    = level_q;

  a_r3_direct_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !indirect_i) |=>
      (done_o && !busy_o && ea_o == $past(base_i) && level_o == '0));

  a_r7_level_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LVL_MAX && !(!busy_o && start_i)) |=> (level_o == LVL_MAX));

  a_r8_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !abort_i && !step_i) |=> (busy_o && !done_o && $stable(cur_addr_o)));

  a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && abort_i) |=> (!busy_o && !done_o));
endmodule

// File: rtl/hpea_resolver.sv
module hpea_resolver
  import hpea_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [15:0]      instr_i,
  input  logic [14:0]      pc_i,
  input  logic [15:0]      acc_a_i,
  input  logic [15:0]      acc_b_i,
  input  logic             abort_i,
  output logic             rd_req_o,
  output logic [14:0]      rd_addr_o,
  input  logic             rd_valid_i,
  input  logic [15:0]      rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [14:0]      ea_o,
  output logic [LVL_W-1:0] level_o
);
  addr_t               base;
  addr_t               cur_addr;
  logic                rd_want;
  logic                step;
  word_t               step_word;
  word_t [ALIAS_N-1:0] alias_words;
  logic                unused_fields;

  assign alias_words   = {acc_b_i, acc_a_i};
  assign unused_fields = ^{instr_i[IND_BIT-1:PAGE_SEL_BIT+1], pc_i[OFFS_W-1:0]};

  hpea_page_base u_page_base (
    .page_sel_i (instr_i[PAGE_SEL_BIT]),
    .pc_page_i  (pc_i[ADDR_W-1:OFFS_W]),
    .offs_i     (instr_i[OFFS_W-1:0]),
    .base_o     (base)
  );

  hpea_walk_ctrl #(.LVL_W(LVL_W)) u_walk_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .indirect_i  (instr_i[IND_BIT]),
    .base_i      (base),
    .step_i      (step),
    .step_word_i (step_word),
    .rd_want_o   (rd_want),
    .cur_addr_o  (cur_addr),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ea_o        (ea_o),
    .level_o     (level_o)
  );

  hpea_alias_port u_alias_port (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_want_i     (rd_want),
    .addr_i        (cur_addr),
    .alias_words_i (alias_words),
    .rd_valid_i    (rd_valid_i),
    .rd_data_i     (rd_data_i),
    .rd_req_o      (rd_req_o),
    .rd_addr_o     (rd_addr_o),
    .step_o        (step),
    .step_word_o   (step_word)
  );

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i && !abort_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r5_ea_moves_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ea_o) |-> done_o);

  a_r9_abort_drops_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && abort_i) |=> !rd_req_o);
endmodule

// File: tb/hpea_resolver_tb_top.sv
`timescale 1ns/1ps
module hpea_resolver_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [14:0] pc_i = '0;
  logic [15:0] acc_a_i = 16'h0ABC;
  logic [15:0] acc_b_i = 16'h1DEF;
  logic        abort_i = 1'b0;
  logic        rd_req_o;
  logic [14:0] rd_addr_o;
  logic        rd_valid_i;
  logic [15:0] rd_data_i;
  logic        busy_o;
  logic        done_o;
  logic [14:0] ea_o;
  logic [7:0]  level_o;

  int checks = 0;
  int fails = 0;
  int lat = 0;
  int n_reads = 0;
  logic [14:0] first_addr = '0;
  logic [14:0] ch_addr [8];
  logic [15:0] ch_data [8];
  int ch_n = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk_i = ~clk_i;

  hpea_resolver dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .instr_i(instr_i),
    .pc_i(pc_i), .acc_a_i(acc_a_i), .acc_b_i(acc_b_i), .abort_i(abort_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .ea_o(ea_o),
    .level_o(level_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_rd(input logic [14:0] a);
    for (int k = 0; k < ch_n; k++) if (ch_addr[k] == a) return ch_data[k];
    return {1'b0, a ^ 15'h1234};
  endfunction

  // independent model of the chain walk
  task automatic exp_walk(input logic [14:0] init, output logic [14:0] ea,
                          output int lv, output int rds);
    logic [14:0] a;
    logic [15:0] w;
    a = init; lv = 0; rds = 0; ea = '0;
    for (int s = 0; s < 64; s++) begin
      if (a == 15'd0) w = acc_a_i;
      else if (a == 15'd1) w = acc_b_i;
      else begin w = mem_rd(a); rds++; end
      lv++;
      if (!w[15]) begin ea = w[14:0]; break; end
      a = w[14:0];
    end
  endtask

  function automatic logic [14:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[14:0] | 15'h0040;
  endfunction

  task automatic build_chain(input logic [14:0] init, input int depth);
    logic [14:0] nxt;
    logic dup;
    ch_n = 0;
    if (init < 15'd2) return;
    ch_addr[0] = init;
    for (int k = 0; k < depth; k++) begin
      do begin
        nxt = next_rand();
        dup = 1'b0;
        for (int j = 0; j <= k; j++) if (ch_addr[j] == nxt) dup = 1'b1;
      end while (dup);
      ch_data[k]   = {1'b1, nxt};
      ch_addr[k+1] = nxt;
      ch_n = k + 1;
    end
  endtask

  // memory model: serves one read at a time after lat cycles
  initial begin
    logic [14:0] a;
    rd_valid_i = 1'b0;
    rd_data_i  = '0;
    forever begin
      @(negedge clk_i);
      if (rd_req_o === 1'b1) begin
        a = rd_addr_o;
        if (n_reads == 0) first_addr = a;
        chk("R6 no request at alias address", {31'd0, a < 15'd2}, 32'd0);
        for (int w = 0; w < lat; w++) begin
          @(negedge clk_i);
          chk("R4 request held with stable address", {16'd0, rd_req_o, rd_addr_o}, {16'd0, 1'b1, a});
        end
        rd_data_i  = mem_rd(a);
        rd_valid_i = 1'b1;
        n_reads++;
        @(negedge clk_i);
        rd_valid_i = 1'b0;
      end
    end
  end

  task automatic resolve(input string req, input logic [15:0] ins, input logic [14:0] pc,
                         input int exp_cyc, input int glitch);
    logic [14:0] init, e_ea;
    int e_lv, e_rd, cyc;
    init = ins[10] ? {pc[14:10], ins[9:0]} : {5'd0, ins[9:0]};
    if (ins[15]) exp_walk(init, e_ea, e_lv, e_rd);
    else begin e_ea = init; e_lv = 0; e_rd = 0; end
    @(negedge clk_i);
    n_reads = 0;
    instr_i = ins; pc_i = pc; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 2000) begin
      if (glitch != 0 && cyc == glitch) begin
        chk("R8 busy when stray start arrives", {31'd0, busy_o}, 32'd1);
        start_i = 1'b1; instr_i = 16'h03AB;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    chk({req, " effective address"}, {17'd0, ea_o}, {17'd0, e_ea});
    chk("R7 level count", {24'd0, level_o}, e_lv);
    chk("R5 memory reads issued", n_reads, e_rd);
    if (ins[15] && init >= 15'd2)
      chk("R4 first read at base address", {17'd0, first_addr}, {17'd0, init});
    if (exp_cyc != 0) chk({req, " done timing"}, cyc, exp_cyc);
    chk("R8 not busy with done", {31'd0, busy_o}, 32'd0);
    @(negedge clk_i);
    chk("R8 done is one cycle", {31'd0, done_o}, 32'd0);
  endtask

  task automatic run_all();
    logic [14:0] pcs [4];
    logic [9:0]  offs [5];
    int vec;
    pcs[0] = 15'h0000; pcs[1] = 15'h2C35; pcs[2] = 15'h7FFF; pcs[3] = 15'h4400;
    offs[0] = 10'h000; offs[1] = 10'h3FF; offs[2] = 10'h155; offs[3] = 10'h2AA; offs[4] = 10'h001;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 busy", {31'd0, busy_o}, 32'd0);
    chk("R10 done", {31'd0, done_o}, 32'd0);
    chk("R10 request", {31'd0, rd_req_o}, 32'd0);
    chk("R10 ea", {17'd0, ea_o}, 32'd0);
    chk("R10 level", {24'd0, level_o}, 32'd0);
    rst_ni = 1'b1;
    vec = 0;
    // sweep: R1 page zero, R2 current page, R3 direct, R5 chains
    for (int p = 0; p < 4; p++)
      for (int z = 0; z < 2; z++)
        for (int d = 0; d < 2; d++)
          for (int o = 0; o < 5; o++) begin
            logic [15:0] ins;
            logic [14:0] init;
            ins  = {d[0], 4'b0101, z[0], offs[o]};
            init = z[0] ? {pcs[p][14:10], offs[o]} : {5'd0, offs[o]};
            lat  = vec % 3;
            build_chain(init, vec % 4);
            if (d == 0)
              resolve(z[0] ? "R2 current page direct" : "R1 page zero direct", ins, pcs[p], 1, 0);
            else
              resolve(z[0] ? "R2 current page indirect" : "R1 page zero indirect", ins, pcs[p], 0, 0);
            vec++;
          end
    // R6: direct word in accumulator A at address 0, exact timing
    ch_n = 0; acc_a_i = 16'h0456;
    resolve("R6 alias A direct", 16'h8000, 15'h1234, 2, 0);
    // R6: accumulator B points into memory
    acc_b_i = 16'h8123; lat = 1;
    resolve("R6 alias B then memory", 16'h8001, 15'h0000, 0, 0);
    // R8: stray start while waiting on a slow read
    lat = 6;
    build_chain(15'h0222, 2);
    resolve("R8 stray start ignored", 16'h8222, 15'h0000, 0, 3);
    lat = 0;
    // R7 saturation and R9 abort on a self-pointing accumulator
    begin
      int seen_done;
      acc_a_i = 16'h8000;
      seen_done = 0;
      @(negedge clk_i);
      instr_i = 16'h8000; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      for (int c = 0; c < 300; c++) begin
        if (done_o) seen_done++;
        @(negedge clk_i);
      end
      chk("R7 level saturates", {24'd0, level_o}, 32'd255);
      chk("R9 still busy before abort", {31'd0, busy_o}, 32'd1);
      chk("R6 self loop issues no request", {31'd0, rd_req_o}, 32'd0);
      abort_i = 1'b1;
      @(negedge clk_i);
      abort_i = 1'b0;
      chk("R9 idle after abort", {31'd0, busy_o}, 32'd0);
      chk("R9 no request after abort", {31'd0, rd_req_o}, 32'd0);
      chk("R9 no done on abort", {31'd0, done_o}, 32'd0);
      chk("R9 no done during loop", seen_done, 32'd0);
      @(negedge clk_i);
      chk("R9 no late done", {31'd0, done_o}, 32'd0);
      chk("R7 level held after abort", {24'd0, level_o}, 32'd255);
    end
    // R7: level cleared by next start
    acc_a_i = 16'h0ABC;
    resolve("R3 direct after abort", 16'h0444, 15'h0000, 1, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk_i);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule